// File: doc/BRIEF.md
# Rule Header Matching FSM

This block compares the header fields of one packet against a signature rule header held in a word-addressed rule memory. A rule sequencer gives it a base address and a start strobe. The matcher then fetches the rule words one at a time through a synchronous read port. It checks the protocol, then the source address, the source port, the destination address and the destination port. Finally it returns a one-cycle ready pulse with a pass or fail status.

The rule begins with a header word that holds packed flags. Address and port words follow only when those flags say the field is present, so short rules take little memory and few cycles. An address is compared under a netmask that comes from a 2-bit prefix code. The mask is applied to both the rule address and the packet address. Any mismatch ends the sequence at once with a fail.

Top module: `rule_header_matcher`

## Requirements
- R1: After reset, `ready` is low and stays low until a `start` has been accepted.
- R2: The header word holds the protocol in bits [1:0] (0 tcp, 1 udp, 2 icmp, 3 ip). A protocol that differs from `pkt_proto` fails the rule straight after the protocol step.
- R3: Header bits [5:4] are the source prefix code and bits [7:6] the destination prefix code. Code 3 means the address is absent: no word is fetched for it and any packet address matches.
- R4: Prefix code 0 compares all 32 bits, code 1 the upper 24 bits and code 2 the upper 16 bits. The mask is applied to both the rule and the packet address, and a masked difference fails the rule.
- R5: Header bit 2 enables the source port check and bit 3 the destination port check, each on its own. An enabled port is taken from bits [15:0] of its word and matches only on full 16-bit equality. A disabled port fetches no word and always matches.
- R6: The present words follow the header at consecutive addresses from `base_addr`, in the order source address, source port, destination address, destination port. `rule_data` carries the word whose address was on `rule_addr` in the previous cycle.
- R7: The steps run in this order: protocol (1 cycle); for each side in turn, address load (1 cycle) plus 3 more cycles when the address is present, then port (1 cycle). `ready` is high in the cycle after the last step that runs.
- R8: `ready` is a one-cycle pulse. `status` is 0 for pass and 1 for fail in the same cycle.
- R9: A `start` that arrives while a check is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check when idle |
| base_addr | input | AW | Address of the rule header word |
| rule_addr | output | AW | Rule memory read address |
| rule_data | input | 32 | Rule word read one cycle after its address |
| pkt_proto | input | 2 | Packet protocol code |
| pkt_src_ip | input | 32 | Packet source address |
| pkt_src_port | input | 16 | Packet source port |
| pkt_dst_ip | input | 32 | Packet destination address |
| pkt_dst_port | input | 16 | Packet destination port |
| ready | output | 1 | One-cycle completion pulse |
| status | output | 1 | 0 pass, 1 fail, valid with ready |

## Verification
A read pointer that is off by one shifts every later field onto the wrong word. That shows as a wrong status once the next present field is compared, and it cannot hide, because the bench lays out every mix of present fields. A wrong state order or a missed early exit changes the number of cycles from start to ready. The bench predicts that count exactly for each run, so such a fault shows on the very next completion. A wrong mask is exposed by flipped packet bits inside and outside each prefix, together with noise placed outside the mask.

// File: rtl/rule_header_matcher.sv
module rule_header_matcher #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  output logic [AW-1:0] rule_addr,
  input  logic [31:0]   rule_data,
  input  logic [1:0]    pkt_proto,
  input  logic [31:0]   pkt_src_ip,
  input  logic [15:0]   pkt_src_port,
  input  logic [31:0]   pkt_dst_ip,
  input  logic [15:0]   pkt_dst_port,
  output logic          ready,
  output logic          status
);
  typedef enum logic [2:0] {S_IDLE, S_PROTO, S_LD, S_NET, S_MSK, S_CMP, S_PORT} st_t;

  st_t           st;
  logic [AW-1:0] ptr;
  logic [7:0]    hdr;
  logic          side;
  logic [31:0]   addr_q, mask_q, a_q, p_q;

  wire [1:0]  code     = side ? hdr[7:6] : hdr[5:4];
  wire        pen      = side ? hdr[3] : hdr[2];
  wire [31:0] pkt_ip   = side ? pkt_dst_ip : pkt_src_ip;
  wire [15:0] pkt_port = side ? pkt_dst_port : pkt_src_port;
  wire        proto_ok = rule_data[1:0] == pkt_proto;
  wire        advance  = (st == S_PROTO && proto_ok) || (st == S_LD && code != 2'd3) ||
                         (st == S_PORT && pen);

  assign rule_addr = (st == S_IDLE) ? base_addr : ptr + AW'(advance);

  function automatic logic [31:0] net_mask(input logic [1:0] c);
    case (c)
      2'd0:    net_mask = 32'hFFFF_FFFF;
      2'd1:    net_mask = 32'hFFFF_FF00;
      2'd2:    net_mask = 32'hFFFF_0000;
      default: net_mask = 32'h0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; hdr <= '0; side <= 1'b0;
      addr_q <= '0; mask_q <= '0; a_q <= '0; p_q <= '0;
      ready <= 1'b0; status <= 1'b0;
    end else begin
      ready <= 1'b0;
      ptr   <= rule_addr;
      case (st)
        S_IDLE: if (start) begin st <= S_PROTO; side <= 1'b0; end
        S_PROTO: begin
          hdr <= rule_data[7:0];
          if (!proto_ok) begin ready <= 1'b1; status <= 1'b1; st <= S_IDLE; end
          else st <= S_LD;
        end
        S_LD: begin
          if (code == 2'd3) st <= S_PORT;
          else begin addr_q <= rule_data; st <= S_NET; end
        end
        S_NET: begin mask_q <= net_mask(code); st <= S_MSK; end
        S_MSK: begin a_q <= addr_q & mask_q; p_q <= pkt_ip & mask_q; st <= S_CMP; end
        S_CMP: begin
          if (a_q != p_q) begin ready <= 1'b1; status <= 1'b1; st <= S_IDLE; end
          else st <= S_PORT;
        end
        S_PORT: begin
          if (pen && rule_data[15:0] != pkt_port) begin
            ready <= 1'b1; status <= 1'b1; st <= S_IDLE;
          end else if (side) begin
            ready <= 1'b1; status <= 1'b0; st <= S_IDLE;
          end else begin
            side <= 1'b1; st <= S_LD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rule_header_matcher_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] rule_addr,
  input logic [31:0]   rule_data,
  input logic [1:0]    pkt_proto,
  input logic [15:0]   pkt_src_port,
  input logic [15:0]   pkt_dst_port,
  input logic          ready,
  input logic          status,
  input logic [2:0]    st,
  input logic [7:0]    hdr,
  input logic          side
);
  wire busy = st != 3'd0;
  wire en   = side ? hdr[3] : hdr[2];
  wire [15:0] port = side ? pkt_dst_port : pkt_src_port;

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  p_no_early_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> !ready);
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (rule_addr == $past(rule_addr) || rule_addr == $past(rule_addr) + 1'b1));
  p_proto_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && rule_data[1:0] != pkt_proto) |=> (ready && status));
  p_port_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6 && en && rule_data[15:0] != port) |=> (ready && status));
endmodule

bind rule_header_matcher rule_header_matcher_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rule_addr(rule_addr), .rule_data(rule_data),
  .pkt_proto(pkt_proto), .pkt_src_port(pkt_src_port), .pkt_dst_port(pkt_dst_port),
  .ready(ready), .status(status), .st(st), .hdr(hdr), .side(side)
);

// File: tb/rule_header_matcher_bench.sv
module rule_header_matcher_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0, rule_addr;
  logic [31:0] rule_data;
  logic [1:0] pkt_proto = '0;
  logic [31:0] pkt_src_ip = '0, pkt_dst_ip = '0;
  logic [15:0] pkt_src_port = '0, pkt_dst_port = '0;
  logic ready, status;
  logic [31:0] mem [64];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) rule_data <= mem[rule_addr[5:0]];

  rule_header_matcher #(.AW(AW)) u_rule_header_matcher (
    .clk, .rst_n, .start, .base_addr, .rule_addr, .rule_data, .pkt_proto,
    .pkt_src_ip, .pkt_src_port, .pkt_dst_ip, .pkt_dst_port, .ready, .status);

  function automatic logic [31:0] msk(input int c);
    if (c == 3) return 32'h0;
    return ~((32'h1 << (8 * c)) - 32'h1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic run(input int base, input bit poke, input bit exp_fail, input int exp_n, input string tag);
    int k;
    @(negedge clk); base_addr = AW'(base); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0; k = 0;
    while (!ready && k < 40) begin
      if (poke && k == 2) begin start = 1; base_addr = AW'(60); end else start = 0;
      @(negedge clk); k++;
    end
    start = 0;
    chk(k == exp_n, "R7 latency", k, exp_n);
    chk(status == exp_fail, tag, status, exp_fail);
    if (poke) chk(status == exp_fail && k == exp_n, "R9 start while busy", status, exp_fail);
    @(negedge clk);
    chk(!ready, "R8 ready pulse", ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ready, "R1 reset ready", ready, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!ready, "R1 idle ready", ready, 0);
    for (int it = 0; it < 1152; it++) begin
      int pm, sc, dc, pe, fk, base, w, n;
      logic [1:0] pr;
      logic [31:0] rs, rd, fs, fd;
      logic [15:0] rsp, rdp;
      bit pok, saok, sdok, spok, dpok, fail;
      string tag;
      pm = it % 2; sc = (it / 2) % 4; dc = (it / 8) % 4; pe = (it / 32) % 4; fk = (it / 128) % 9;
      pr = 2'(it / 3); base = (it * 7) % 40;
      rs = 32'hC0A8_0000 ^ 32'(it * 977); rd = 32'h0A01_0000 ^ 32'(it * 313);
      rsp = 16'h0050 + 16'(it); rdp = 16'h1F90 ^ 16'(it);
      for (int j = 0; j < 6; j++) mem[base + j] = 32'hDEAD_0000 + 32'(j);
      w = base;
      mem[w++] = {24'h0, 2'(dc), 2'(sc), 2'(pe), pr};
      if (sc != 3) mem[w++] = rs;
      if (pe[0]) mem[w++] = {16'hBEEF, rsp};
      if (dc != 3) mem[w++] = rd;
      if (pe[1]) mem[w++] = {16'hBEEF, rdp};
      fs = (fk == 1) ? 32'h10 : (fk == 2) ? 32'h1000 : (fk == 3) ? 32'h1000_0000 : 32'h0;
      fd = (fk == 5) ? 32'h10 : (fk == 6) ? 32'h1000 : (fk == 7) ? 32'h1000_0000 : 32'h0;
      pkt_proto    = pm ? pr ^ 2'd1 : pr;
      pkt_src_ip   = rs ^ fs ^ (~msk(sc) & 32'h2121_2121);
      pkt_dst_ip   = rd ^ fd ^ (~msk(dc) & 32'h2121_2121);
      pkt_src_port = rsp ^ ((fk == 4) ? 16'h8000 : 16'h0);
      pkt_dst_port = rdp ^ ((fk == 8) ? 16'h0001 : 16'h0);
      pok  = (pm == 0);
      saok = (sc == 3) || ((fs & msk(sc)) == 0);
      spok = !pe[0] || fk != 4;
      sdok = (dc == 3) || ((fd & msk(dc)) == 0);
      dpok = !pe[1] || fk != 8;
      n = 1; fail = 0;
      if (!pok) fail = 1;
      else begin
        n += 1 + ((sc != 3) ? 3 : 0);
        if (!saok) fail = 1;
        else begin
          n += 1;
          if (!spok) fail = 1;
          else begin
            n += 1 + ((dc != 3) ? 3 : 0);
            if (!sdok) fail = 1;
            else begin n += 1; if (!dpok) fail = 1; end
          end
        end
      end
      if (!pok) tag = "R2 protocol";
      else if (fk == 4 || fk == 8) tag = "R5 port";
      else if (fk != 0 && (fk < 4 ? sc : dc) == 3) tag = "R3 absent address";
      else if (fk != 0) tag = "R4 masked address";
      else tag = "R6 layout";
      run(base, 0, fail, n, tag);
    end
    mem[60] = 32'h0000_0003;
    for (int t = 0; t < 4; t++) begin
      mem[t * 8] = {24'h0, 2'd0, 2'd1, 2'd3, 2'(t)};
      mem[t * 8 + 1] = 32'h1122_3344; mem[t * 8 + 2] = 32'h0000_0016;
      mem[t * 8 + 3] = 32'h5566_7788; mem[t * 8 + 4] = 32'h0000_01BB;
      pkt_proto = 2'(t); pkt_src_ip = 32'h1122_33AA; pkt_src_port = 16'h0016;
      pkt_dst_ip = 32'h5566_7788; pkt_dst_port = 16'h01BB;
      run(t * 8, 1, 0, 11, "R9 status");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule